// File: doc/BRIEF.md
# Four-Phase Flag-Driven Sequencer Core

This block is a small processor that runs one instruction at a time and gives each instruction four clock cycles. In the first cycle it puts the instruction pointer on a shared memory port. In the second it captures the returned word in an internal instruction register. In the third it carries out the operation. In the fourth it updates the pointer. Instructions and data share a single word-addressed memory with synchronous reads. A read issued in one cycle returns its data in the next cycle.

The core holds four 16-bit general registers and three hidden condition bits: equal, greater and less. Only the compare instruction writes these bits. Every branch is a separate opcode that tests them. The core stops on a halt instruction and stays stopped until reset. Debug outputs show the pointer, the condition bits and all registers, so that a program's effect can be observed.

The control state machine has five named states:
- FETCH: issues a read at the pointer, then goes to DECODE.
- DECODE: latches the instruction word, then goes to EXEC.
- EXEC: performs the operation. It goes to STOPPED if the opcode is halt, and to UPDATE otherwise.
- UPDATE: completes a load, moves the pointer, then goes to FETCH.
- STOPPED: goes only to itself.

Top module: `tiny_seq_cpu`

## Requirements
- R1: While reset is high, and in the cycle after it falls, the pointer is 0, all registers are 0, all condition bits are 0 and `halted` is 0.
- R2: Every instruction other than halt takes exactly four cycles. In the first of those cycles `mem_re` is 1 and `mem_addr` equals the pointer. A program that loads 5 and 10, adds them and stores the sum has 15 in its result word and pointer 4 after 16 cycles.
- R3: The instruction word is laid out as follows: opcode in [31:28], rd in [27:26], rs1 in [25:24], rs2 in [23:22], address or target in [15:0]. Bits [21:16] are zero.
- R4: Opcode 0 (load) writes the low 16 bits of memory[target] into rd. Opcode 1 (store) writes rs1, zero-extended, to memory[target] and leaves rs1 unchanged.
- R5: Opcode 2 (move) copies rs1 into rd.
- R6: Opcodes 3 to 7 write the result of rs1 op rs2 into rd, modulo 2^16. The operations are 3 add, 4 subtract (rs1 minus rs2), 5 and, 6 or, 7 xor. rd may also be a source.
- R7: Opcode 8 (compare) writes no register. It sets exactly one condition bit by unsigned comparison of rs1 with rs2. `dbg_flags` is {equal, greater, less}.
- R8: Load, store, move, ALU ops and jumps leave the condition bits unchanged.
- R9: Opcode 9 always loads the target into the pointer.
- R10: Opcodes A (equal), B (not equal), C (greater) and D (less) load the target when their condition holds. Otherwise they advance the pointer by one.
- R11: Opcode F stops the core. After it, `halted` stays 1, the pointer is frozen and there is no memory access.
- R12: Every instruction that is not a jump advances the pointer by exactly one. Opcode E does nothing but advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address |
| mem_re | output | 1 | Read request; data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| halted | output | 1 | Core has stopped |
| dbg_pc | output | 16 | Instruction pointer |
| dbg_flags | output | 3 | {equal, greater, less} |
| dbg_regs | output | 64 | R0 in [15:0] up to R3 in [63:48] |

## Verification
A wrong control state would appear at the memory port in the very next cycle. The bench would see a read at an address other than the pointer, a missing read, or a stray write. A wrong pointer or a wrong branch decision leads the core onto unused words, which hold halt. The core would then stop at a different pointer value, with a result word that differs or is missing. A corrupted condition bit or register shows on `dbg_flags` or `dbg_regs` at the end of the program.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_MOVE  = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_AND   = 4'h5,
        OP_OR    = 4'h6,
        OP_XOR   = 4'h7,
        OP_CMP   = 4'h8,
        OP_JMP   = 4'h9,
        OP_JE    = 4'hA,
        OP_JNE   = 4'hB,
        OP_JG    = 4'hC,
        OP_JLT   = 4'hD,
        OP_SPARE = 4'hE,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_UPDATE,
        S_STOPPED
    } state_e;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cond_t;

endpackage

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SEL_W-1:0]       waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [SEL_W-1:0]       raddr_a,
    input  logic [SEL_W-1:0]       raddr_b,
    output logic [DATA_W-1:0]      rdata_a,
    output logic [DATA_W-1:0]      rdata_b,
    output logic [NREG*DATA_W-1:0] all_regs
);
    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '{default: '0};
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign all_regs[g*DATA_W +: DATA_W] = regs[g];
    end
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
    import tcpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output cond_t             cmp
);
    always_comb begin
        case (op)
            OP_MOVE: y = a;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end

    always_comb begin
        cmp.eq = (a == b);
        cmp.gt = (a > b);
        cmp.lt = (a < b);
    end
endmodule

// File: rtl/tcpu_branch.sv
module tcpu_branch
    import tcpu_pkg::*;
(
    input  opcode_e op,
    input  cond_t   cond,
    output logic    take
);
    always_comb begin
        case (op)
            OP_JMP:  take = 1'b1;
            OP_JE:   take = cond.eq;
            OP_JNE:  take = !cond.eq;
            OP_JG:   take = cond.gt;
            OP_JLT:  take = cond.lt;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/tiny_seq_cpu.sv
module tiny_seq_cpu
    import tcpu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 32,
    parameter int NREG    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_re,
    output logic                   mem_we,
    output logic [INSTR_W-1:0]     mem_wdata,
    input  logic [INSTR_W-1:0]     mem_rdata,
    output logic                   halted,
    output logic [ADDR_W-1:0]      dbg_pc,
    output logic [2:0]             dbg_flags,
    output logic [NREG*DATA_W-1:0] dbg_regs
);
    localparam int SEL_W   = $clog2(NREG);
    localparam int OPC_LSB = INSTR_W - 4;
    localparam int RD_LSB  = OPC_LSB - SEL_W;
    localparam int RS1_LSB = RD_LSB - SEL_W;
    localparam int RS2_LSB = RS1_LSB - SEL_W;

    state_e               state, state_nx;
    logic [INSTR_W-1:0]   ir;
    logic [ADDR_W-1:0]    pc;
    cond_t                flags;

    opcode_e              op;
    logic [SEL_W-1:0]     rd, rs1, rs2;
    logic [ADDR_W-1:0]    tgt;
    logic [DATA_W-1:0]    rdata_a, rdata_b, alu_y, rf_wdata;
    cond_t                cmp;
    logic                 take, rf_we;

    assign op  = opcode_e'(ir[INSTR_W-1:OPC_LSB]);
    assign rd  = ir[RD_LSB  +: SEL_W];
    assign rs1 = ir[RS1_LSB +: SEL_W];
    assign rs2 = ir[RS2_LSB +: SEL_W];
    assign tgt = ir[ADDR_W-1:0];

    tcpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) i_regfile (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rd), .wdata(rf_wdata),
        .raddr_a(rs1), .raddr_b(rs2), .rdata_a(rdata_a), .rdata_b(rdata_b),
        .all_regs(dbg_regs)
    );

    tcpu_alu #(.DATA_W(DATA_W)) i_alu (
        .op(op), .a(rdata_a), .b(rdata_b), .y(alu_y), .cmp(cmp)
    );

    tcpu_branch i_branch (.op(op), .cond(flags), .take(take));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_FETCH:   state_nx = S_DECODE;
            S_DECODE:  state_nx = S_EXEC;
            S_EXEC:    state_nx = (op == OP_HALT) ? S_STOPPED : S_UPDATE;
            S_UPDATE:  state_nx = S_FETCH;
            S_STOPPED: state_nx = S_STOPPED;
            default:   state_nx = S_FETCH;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ir    <= '0;
            pc    <= '0;
            flags <= '0;
        end else begin
            if (state == S_DECODE) ir <= mem_rdata;
            if (state == S_EXEC && op == OP_CMP) flags <= cmp;
            if (state == S_UPDATE) pc <= take ? tgt : pc + ADDR_W'(1);
        end
    end

    // outputs and register write control
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = tgt;
        mem_wdata = {{(INSTR_W-DATA_W){1'b0}}, rdata_a};
        rf_we     = 1'b0;
        rf_wdata  = alu_y;
        unique case (state)
            S_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = pc;
            end
            S_EXEC: begin
                mem_re = (op == OP_LOAD);
                mem_we = (op == OP_STORE);
                rf_we  = (op inside {OP_MOVE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR});
            end
            S_UPDATE: begin
                rf_we    = (op == OP_LOAD);
                rf_wdata = mem_rdata[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    assign halted    = (state == S_STOPPED);
    assign dbg_pc    = pc;
    assign dbg_flags = flags;

    assert_fetch_at_pc_R2: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |-> mem_re && mem_addr == pc);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        state == S_EXEC |-> ir[RS2_LSB-1:ADDR_W] == '0);
    assert_single_cond_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));
    assert_cond_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(state == S_EXEC && op == OP_CMP) |=> $stable(flags));
    assert_pc_only_update_R12: assert property (@(posedge clk) disable iff (rst)
        state != S_UPDATE |=> $stable(pc));
    assert_stop_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc));
    assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_re && !mem_we);
endmodule

// File: tb/test_tiny_seq_cpu.sv
module test_tiny_seq_cpu;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] HALT_OP = 4'hF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        halted;
    logic [15:0] dbg_pc;
    logic [2:0]  dbg_flags;
    logic [63:0] dbg_regs;
    logic [31:0] mem [256];

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiny_seq_cpu i_tiny_seq_cpu (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted), .dbg_pc(dbg_pc), .dbg_flags(dbg_flags), .dbg_regs(dbg_regs)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [31:0] enc(logic [3:0] op, logic [1:0] rd,
                                        logic [1:0] s1, logic [1:0] s2, logic [15:0] t);
        return {op, rd, s1, s2, 6'b0, t};
    endfunction

    function automatic logic [15:0] expect_op(logic [3:0] op, logic [15:0] a, logic [15:0] b);
        case (op)
            4'h2:    return a;
            4'h3:    return 16'(a + b);
            4'h4:    return 16'(a - b);
            4'h5:    return a & b;
            4'h6:    return a | b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = {HALT_OP, 28'h0};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " watchdog"}, {63'b0, halted}, 64'd1);
    endtask

    // {op, a, b}
    localparam logic [35:0] VEC [8] = '{
        {4'h3, 16'd5,     16'd10},
        {4'h3, 16'hFFFF,  16'h0002},
        {4'h4, 16'd3,     16'd5},
        {4'h4, 16'd9,     16'd9},
        {4'h5, 16'hF0F0,  16'h3C3C},
        {4'h6, 16'hF000,  16'h000F},
        {4'h7, 16'hAAAA,  16'hFFFF},
        {4'h2, 16'h1234,  16'h8000}
    };

    initial begin
        // R1: reset state
        clear_mem();
        do_reset();
        chk("R1 pc", 64'(dbg_pc), 64'd0);
        chk("R1 regs", dbg_regs, 64'd0);
        chk("R1 flags", 64'(dbg_flags), 64'd0);
        chk("R1 halted", {63'b0, halted}, 64'd0);
        // R2: first cycle reads at pointer
        chk("R2 fetch", {46'b0, mem_re, mem_we, mem_addr}, {46'b0, 1'b1, 1'b0, 16'd0});

        // R2: exact timing of 5+10 program
        clear_mem();
        mem[0] = enc(4'h0, 2'd1, 2'd0, 2'd0, 16'd100);
        mem[1] = enc(4'h0, 2'd2, 2'd0, 2'd0, 16'd101);
        mem[2] = enc(4'h3, 2'd3, 2'd1, 2'd2, 16'd0);
        mem[3] = enc(4'h1, 2'd0, 2'd3, 2'd0, 16'd102);
        mem[100] = 32'd5; mem[101] = 32'd10; mem[102] = 32'd0;
        do_reset();
        repeat (12) @(negedge clk);
        chk("R2 pc after 12 cycles", 64'(dbg_pc), 64'd3);
        chk("R2 no result yet", 64'(mem[102]), 64'd0);
        repeat (4) @(negedge clk);
        chk("R2 pc after 16 cycles", 64'(dbg_pc), 64'd4);
        chk("R2 sum stored", 64'(mem[102]), 64'd15);

        // Vector table: R3 R4 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            logic [3:0]  op = VEC[v][35:32];
            logic [15:0] a  = VEC[v][31:16];
            logic [15:0] b  = VEC[v][15:0];
            clear_mem();
            mem[0] = enc(4'h0, 2'd1, 2'd0, 2'd0, 16'd100);
            mem[1] = enc(4'h0, 2'd2, 2'd0, 2'd0, 16'd101);
            mem[2] = enc(op,   2'd3, 2'd1, 2'd2, 16'd0);
            mem[3] = enc(4'h1, 2'd0, 2'd3, 2'd0, 16'd102);
            mem[4] = enc(4'h8, 2'd0, 2'd1, 2'd2, 16'd0);
            mem[100] = {16'hBEEF, a}; mem[101] = {16'h0, b}; mem[102] = 32'hDEAD;
            do_reset();
            run_to_halt("R11");
            chk("R6 result word", 64'(mem[102]), 64'({16'h0, expect_op(op, a, b)}));
            chk("R7 flags", 64'(dbg_flags), 64'({a == b, a > b, a < b}));
            chk("R4 source kept", 64'(dbg_regs[63:48]), 64'(expect_op(op, a, b)));
            chk("R12 halt pointer", 64'(dbg_pc), 64'd5);
        end

        // R9 R10: branch chain, wrong paths land on halt elsewhere
        clear_mem();
        mem[0]  = enc(4'h0, 2'd1, 2'd0, 2'd0, 16'd100);
        mem[1]  = enc(4'h0, 2'd2, 2'd0, 2'd0, 16'd101);
        mem[2]  = enc(4'h8, 2'd0, 2'd1, 2'd2, 16'd0);
        mem[3]  = enc(4'hB, 2'd0, 2'd0, 2'd0, 16'd40);
        mem[4]  = enc(4'hA, 2'd0, 2'd0, 2'd0, 16'd6);
        mem[6]  = enc(4'hC, 2'd0, 2'd0, 2'd0, 16'd41);
        mem[7]  = enc(4'hD, 2'd0, 2'd0, 2'd0, 16'd42);
        mem[8]  = enc(4'h0, 2'd1, 2'd0, 2'd0, 16'd102);
        mem[9]  = enc(4'h8, 2'd0, 2'd1, 2'd2, 16'd0);
        mem[10] = enc(4'hD, 2'd0, 2'd0, 2'd0, 16'd13);
        mem[13] = enc(4'h9, 2'd0, 2'd0, 2'd0, 16'd15);
        mem[15] = enc(4'h8, 2'd0, 2'd2, 2'd1, 16'd0);
        mem[16] = enc(4'hC, 2'd0, 2'd0, 2'd0, 16'd18);
        mem[18] = enc(4'hB, 2'd0, 2'd0, 2'd0, 16'd21);
        mem[21] = enc(4'h1, 2'd0, 2'd2, 2'd0, 16'd103);
        mem[100] = 32'd7; mem[101] = 32'd7; mem[102] = 32'd3; mem[103] = 32'd0;
        do_reset();
        run_to_halt("R10");
        chk("R10 branch path end", 64'(dbg_pc), 64'd22);
        chk("R9 marker stored", 64'(mem[103]), 64'd7);

        // R5 R6 R8 R12: move, sub in place, spare opcode, flags preserved
        clear_mem();
        mem[0] = enc(4'h0, 2'd1, 2'd0, 2'd0, 16'd100);
        mem[1] = enc(4'h0, 2'd2, 2'd0, 2'd0, 16'd101);
        mem[2] = enc(4'h8, 2'd0, 2'd1, 2'd2, 16'd0);
        mem[3] = enc(4'h4, 2'd1, 2'd1, 2'd2, 16'd0);
        mem[4] = enc(4'h2, 2'd0, 2'd1, 2'd0, 16'd0);
        mem[5] = enc(4'hE, 2'd3, 2'd1, 2'd2, 16'd100);
        mem[6] = enc(4'h3, 2'd3, 2'd0, 2'd2, 16'd0);
        mem[100] = 32'd10; mem[101] = 32'd3;
        do_reset();
        run_to_halt("R12");
        chk("R12 pointer", 64'(dbg_pc), 64'd7);
        chk("R6 in-place sub R1", 64'(dbg_regs[31:16]), 64'd7);
        chk("R5 move into R0", 64'(dbg_regs[15:0]), 64'd7);
        chk("R7 compare left R2", 64'(dbg_regs[47:32]), 64'd3);
        chk("R6 add R3", 64'(dbg_regs[63:48]), 64'd10);
        chk("R8 flags kept greater", 64'(dbg_flags), 64'b010);

        // R11: stays stopped, no memory traffic
        repeat (20) begin
            @(negedge clk);
            chk("R11 sticky", {45'b0, halted, mem_re, mem_we, dbg_pc}, {45'b0, 1'b1, 1'b0, 1'b0, 16'd7});
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule